// File: doc/BRIEF.md
# SPI Target Peripheral with Byte FIFOs

This block lets an external SPI controller exchange byte streams with an on-chip host. Bytes clocked in on MOSI while chip select is low are collected into a receive FIFO. Bytes shifted out on MISO are taken from a transmit FIFO. When the transmit FIFO has nothing to offer, or is switched off, a programmable idle byte is sent instead. The SPI pins are oversampled in the system clock domain, so SCK must run at no more than one eighth of the system clock. All four clock polarity and phase combinations are supported, and bit order can be chosen separately for each direction.

The host reaches the block through a flat register port: one address, a write strobe, write data, and combinational read data. Each FIFO has two pointers. Each pointer is one bit wider than the FIFO index, and that extra bit marks a lap of the buffer. The block advances the receive write pointer and the transmit read pointer. The host advances the other two by writing them. Received data is read one byte at a time through a peek register at the receive read pointer. Transmit data is written as whole 32-bit words at the word that holds the transmit write pointer. Two interrupt lines report the receive fill level and the end of a chip-select frame. Inside the block, the engine-to-FIFO paths are valid/take pulses. The receive side applies no back-pressure: a byte that meets a full FIFO is lost and flagged. The transmit side always supplies a byte when the engine takes one.

Top module: `spit_core`

## Requirements
- R1: After reset, CTRL (addr 0) reads 0xC, FIFOCTL (addr 1) reads 0, IDLE (addr 2) reads 0xFF, STATUS (addr 5) reads 0x4, and all four pointers read 0. The pointer addresses are RXWP 7, RXRP 8, TXWP 9 and TXRP 10.
- R2: CTRL bit0 is phase and bit1 is polarity. Bit3 selects MSB-first reception and bit2 selects MSB-first transmission. Every byte received in each of the four modes and both bit orders is stored in order. RXPEEK (addr 11) returns the byte at the receive read index.
- R3: A write to TXWORD (addr 12) stores byte lane k (wdata[8k+7:8k]) at index 4·i+k, where i is the word index of TXWP. Once TXWP is advanced, MISO sends those bytes in index order, and TXRP goes up by one for each byte sent.
- R4: MISO sends IDLE, which is 0xFF after reset and can be changed, whenever the TX FIFO is empty or its enable bit (FIFOCTL bit1) is clear. In that case TXRP does not move.
- R5: Pointers are AW+1 bits wide. The block increments RXWP by one for each stored byte, and the pointer wraps through its top bit. The FIFO is full when the pointers differ only in the top bit.
- R6: A byte received while the RX FIFO is full is dropped, and sticky STATUS bit3 is set. Writing 1 to CLR (addr 6) bit3 clears that flag.
- R7: STATUS bit0 is high while (RXWP−RXRP) exceeds THRESH (addr 3). Output irq_rx_level equals this bit ANDed with INTEN (addr 4) bit0, so it falls once the host advances RXRP.
- R8: The rising edge of chip select sets sticky STATUS bit1. Output irq_cs_deassert equals this bit ANDed with INTEN bit1. Writing 1 to CLR bit1 clears the flag.
- R9: FIFOCTL bit0 and bit3 reset the TX and RX FIFO respectively. Both pointers of that FIFO go to 0, and the reset bit reads 0 again on the next cycle.
- R10: When auto-disable is set (FIFOCTL bit2 for TX, bit5 for RX), the matching enable bit (bit1, bit4) clears when chip select rises.
- R11: A partial byte left when chip select rises is discarded. The next frame starts on a byte boundary.
- R12: While RX enable (FIFOCTL bit4) is clear, received bytes are discarded: RXWP stays put and STATUS bit3 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | input | 1 | SPI clock from the controller |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, high when deselected |
| irq_rx_level | output | 1 | Receive level interrupt |
| irq_cs_deassert | output | 1 | Chip-select end interrupt |

## Verification
The bench builds the block with AW = 4. Each FIFO then holds 16 bytes and each pointer is 5 bits wide, so a single frame of 17 bytes hits the full boundary and overflow. A few dozen bytes wrap both pointers through their top bit more than once. At that size, a full sweep of the four clock modes times the two bit orders takes only a few thousand cycles. In that sweep, every expected MOSI and MISO byte is generated arithmetically from the sweep index.

// File: rtl/spit_pkg.sv
package spit_pkg;

  typedef struct packed {
    logic rx_msb;
    logic tx_msb;
    logic cpol;
    logic cpha;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_RESET = '{rx_msb: 1'b1, tx_msb: 1'b1, cpol: 1'b0, cpha: 1'b0};

  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_FIFOCTL = 4'd1;
  localparam logic [3:0] A_IDLE    = 4'd2;
  localparam logic [3:0] A_THRESH  = 4'd3;
  localparam logic [3:0] A_INTEN   = 4'd4;
  localparam logic [3:0] A_STATUS  = 4'd5;
  localparam logic [3:0] A_CLR     = 4'd6;
  localparam logic [3:0] A_RXWP    = 4'd7;
  localparam logic [3:0] A_RXRP    = 4'd8;
  localparam logic [3:0] A_TXWP    = 4'd9;
  localparam logic [3:0] A_TXRP    = 4'd10;
  localparam logic [3:0] A_RXPEEK  = 4'd11;
  localparam logic [3:0] A_TXWORD  = 4'd12;

  localparam logic [7:0] IDLE_RESET = 8'hFF;

endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{INIT[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end

endmodule

// File: rtl/spit_engine.sv
module spit_engine
  import spit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       csn_s,
  input  logic       mosi_s,
  input  spi_cfg_t   cfg,
  output logic       tx_take,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       cs_begin,
  output logic       cs_end,
  output logic       miso
);

  logic       sck_q, csn_q;
  logic       in_frame, rise, fall, lead, trail, sample_ev, shift_ev;
  logic [2:0] in_cnt, out_cnt, tx_idx;
  logic       hold;
  logic [7:0] rx_sh, rx_next, cur_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  assign cs_begin  = csn_q & ~csn_s;
  assign cs_end    = ~csn_q & csn_s;
  assign in_frame  = ~csn_s & ~csn_q;
  assign rise      = sck_s & ~sck_q;
  assign fall      = ~sck_s & sck_q;
  assign lead      = in_frame & (cfg.cpol ? fall : rise);
  assign trail     = in_frame & (cfg.cpol ? rise : fall);
  assign sample_ev = cfg.cpha ? trail : lead;
  assign shift_ev  = cfg.cpha ? lead : trail;

  assign rx_next = cfg.rx_msb ? {rx_sh[6:0], mosi_s} : {mosi_s, rx_sh[7:1]};
  assign tx_take = cs_begin | (shift_ev & ~hold & (out_cnt == 3'd7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt   <= '0;
      out_cnt  <= '0;
      hold     <= 1'b0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      cur_tx   <= 8'hFF;
    end else begin
      rx_valid <= 1'b0;
      if (cs_begin) begin
        in_cnt  <= '0;
        out_cnt <= '0;
        hold    <= cfg.cpha;
      end else begin
        if (sample_ev) begin
          rx_sh  <= rx_next;
          in_cnt <= in_cnt + 3'd1;
          if (in_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_next;
          end
        end
        if (shift_ev) begin
          if (hold) hold <= 1'b0;
          else      out_cnt <= out_cnt + 3'd1;
        end
      end
      if (tx_take) cur_tx <= tx_byte;
    end
  end

  assign tx_idx = cfg.tx_msb ? (3'd7 - out_cnt) : out_cnt;
  assign miso   = csn_s ? 1'b1 : cur_tx[tx_idx];

endmodule

// File: rtl/spit_rx_fifo.sv
module spit_rx_fifo #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        push,
  input  logic [7:0]  push_data,
  input  logic        rptr_wr,
  input  logic [AW:0] rptr_wdata,
  output logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic        full,
  output logic [7:0]  head
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic       accept;

  assign full   = (wptr ^ rptr) == {1'b1, {AW{1'b0}}};
  assign accept = push & ~full & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (accept)  wptr <= wptr + 1'b1;
      if (rptr_wr) rptr <= rptr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr[AW-1:0]] <= push_data;
  end

  assign head = mem[rptr[AW-1:0]];

endmodule

// File: rtl/spit_tx_fifo.sv
module spit_tx_fifo #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        word_wr,
  input  logic [31:0] word_data,
  input  logic        wptr_wr,
  input  logic [AW:0] wptr_wdata,
  input  logic        pop,
  output logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic        empty,
  output logic [7:0]  head
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  assign empty = (wptr == rptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wptr_wr)      wptr <= wptr_wdata;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (word_wr) begin
      for (int k = 0; k < 4; k++) begin
        mem[{wptr[AW-1:2], 2'(k)}] <= word_data[8*k +: 8];
      end
    end
  end

  assign head = mem[rptr[AW-1:0]];

endmodule

// File: rtl/spit_core.sv
module spit_core
  import spit_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        irq_rx_level,
  output logic        irq_cs_deassert
);

  localparam int PW = AW + 1;

  spi_cfg_t   cfg;
  logic       tx_en, tx_ad, tx_rst_q, rx_en, rx_ad, rx_rst_q;
  logic [7:0] idle;
  logic [PW-1:0] thresh;
  logic [1:0] ien;
  logic       cs_flag, ovf_flag;

  logic [2:0] pins_s;
  logic       eng_take, eng_rx_valid, eng_cs_begin, eng_cs_end;
  logic [7:0] eng_rx_data, eng_tx_byte;

  logic [PW-1:0] rx_wptr, rx_rptr, tx_wptr, tx_rptr, rx_count;
  logic          rx_full, tx_empty, tx_pop, rx_lvl;
  logic [7:0]    rx_head, tx_head;

  logic wr_ctrl, wr_fifoctl, wr_clr, cs_clr, ovf_clr, ovf_set;

  spit_sync #(.W(3), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_csn, spi_mosi}),
    .q(pins_s)
  );

  spit_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[2]), .csn_s(pins_s[1]), .mosi_s(pins_s[0]),
    .cfg(cfg),
    .tx_take(eng_take), .tx_byte(eng_tx_byte),
    .rx_valid(eng_rx_valid), .rx_data(eng_rx_data),
    .cs_begin(eng_cs_begin), .cs_end(eng_cs_end),
    .miso(spi_miso)
  );

  assign tx_pop      = eng_take & tx_en & ~tx_empty;
  assign eng_tx_byte = tx_pop ? tx_head : idle;

  spit_rx_fifo #(.AW(AW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst_q),
    .push(eng_rx_valid & rx_en), .push_data(eng_rx_data),
    .rptr_wr(reg_wr && reg_addr == A_RXRP), .rptr_wdata(reg_wdata[PW-1:0]),
    .wptr(rx_wptr), .rptr(rx_rptr), .full(rx_full), .head(rx_head)
  );

  spit_tx_fifo #(.AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst_q),
    .word_wr(reg_wr && reg_addr == A_TXWORD), .word_data(reg_wdata),
    .wptr_wr(reg_wr && reg_addr == A_TXWP), .wptr_wdata(reg_wdata[PW-1:0]),
    .pop(tx_pop),
    .wptr(tx_wptr), .rptr(tx_rptr), .empty(tx_empty), .head(tx_head)
  );

  assign rx_count = rx_wptr - rx_rptr;
  assign rx_lvl   = rx_count > thresh;

  assign wr_ctrl    = reg_wr && reg_addr == A_CTRL;
  assign wr_fifoctl = reg_wr && reg_addr == A_FIFOCTL;
  assign wr_clr     = reg_wr && reg_addr == A_CLR;
  assign cs_clr     = wr_clr & reg_wdata[1];
  assign ovf_clr    = wr_clr & reg_wdata[3];
  assign ovf_set    = eng_rx_valid & rx_en & rx_full & ~rx_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= CFG_RESET;
      tx_en    <= 1'b0;
      tx_ad    <= 1'b0;
      tx_rst_q <= 1'b0;
      rx_en    <= 1'b0;
      rx_ad    <= 1'b0;
      rx_rst_q <= 1'b0;
      idle     <= IDLE_RESET;
      thresh   <= '0;
      ien      <= '0;
      cs_flag  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      tx_rst_q <= 1'b0;
      rx_rst_q <= 1'b0;
      if (eng_cs_end) begin
        if (tx_ad) tx_en <= 1'b0;
        if (rx_ad) rx_en <= 1'b0;
      end
      if (wr_ctrl) cfg <= spi_cfg_t'(reg_wdata[3:0]);
      if (wr_fifoctl) {rx_ad, rx_en, rx_rst_q, tx_ad, tx_en, tx_rst_q} <= reg_wdata[5:0];
      if (reg_wr && reg_addr == A_IDLE)   idle   <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_THRESH) thresh <= reg_wdata[PW-1:0];
      if (reg_wr && reg_addr == A_INTEN)  ien    <= reg_wdata[1:0];
      if (eng_cs_end)  cs_flag <= 1'b1;
      else if (cs_clr) cs_flag <= 1'b0;
      if (ovf_set)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:    reg_rdata[3:0] = cfg;
      A_FIFOCTL: reg_rdata[5:0] = {rx_ad, rx_en, rx_rst_q, tx_ad, tx_en, tx_rst_q};
      A_IDLE:    reg_rdata[7:0] = idle;
      A_THRESH:  reg_rdata[PW-1:0] = thresh;
      A_INTEN:   reg_rdata[1:0] = ien;
      A_STATUS:  reg_rdata[3:0] = {ovf_flag, tx_empty, cs_flag, rx_lvl};
      A_RXWP:    reg_rdata[PW-1:0] = rx_wptr;
      A_RXRP:    reg_rdata[PW-1:0] = rx_rptr;
      A_TXWP:    reg_rdata[PW-1:0] = tx_wptr;
      A_TXRP:    reg_rdata[PW-1:0] = tx_rptr;
      A_RXPEEK:  reg_rdata[7:0] = rx_head;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_rx_level    = rx_lvl & ien[0];
  assign irq_cs_deassert = cs_flag & ien[1];

endmodule

// File: rtl/spit_core_checks.sv
module spit_core_checks #(
  parameter int AW = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic [AW:0] rx_wptr,
  input logic        rx_full,
  input logic        rx_rst,
  input logic [AW:0] tx_wptr,
  input logic [AW:0] tx_rptr,
  input logic        tx_empty,
  input logic        tx_take,
  input logic        tx_rst,
  input logic        cs_flag,
  input logic        cs_clr
);

  assert_rx_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wptr != $past(rx_wptr)) |-> (rx_wptr == $past(rx_wptr) + 1'b1 || rx_wptr == '0));

  assert_no_store_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rst) |=> $stable(rx_wptr));

  assert_idle_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_empty && !tx_rst) |=> $stable(tx_rptr));

  assert_fifo_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (tx_wptr == '0 && tx_rptr == '0));

  assert_cs_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_flag && !cs_clr) |=> cs_flag);

endmodule

bind spit_core spit_core_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .rx_wptr(rx_wptr), .rx_full(rx_full), .rx_rst(rx_rst_q),
  .tx_wptr(tx_wptr), .tx_rptr(tx_rptr), .tx_empty(tx_empty),
  .tx_take(eng_take), .tx_rst(tx_rst_q),
  .cs_flag(cs_flag), .cs_clr(cs_clr)
);

// File: tb/spit_core_test.sv
module spit_core_test;

  localparam int AW   = 4;
  localparam int HALF = 8;

  localparam logic [3:0] R_CTRL = 4'd0, R_FCTL = 4'd1, R_IDLE = 4'd2, R_THR = 4'd3,
                         R_IEN = 4'd4, R_STAT = 4'd5, R_CLR = 4'd6, R_RXWP = 4'd7,
                         R_RXRP = 4'd8, R_TXWP = 4'd9, R_TXRP = 4'd10, R_PEEK = 4'd11,
                         R_WORD = 4'd12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, irq_rx_level, irq_cs_deassert;

  int n_chk = 0, n_fail = 0;
  logic cpol_m = 1'b0, cpha_m = 1'b0, msb_m = 1'b1;

  always #10 clk = ~clk;

  spit_core #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .irq_rx_level(irq_rx_level), .irq_cs_deassert(irq_cs_deassert)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin();
    @(negedge clk);
    spi_sck = cpol_m;
    wait_clk(4);
    spi_csn = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic spi_end();
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nb, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nb; i++) begin
      int b;
      b = msb_m ? 7 - i : i;
      if (!cpha_m) begin
        spi_mosi = mo[b];
        wait_clk(HALF);
        mi[b] = spi_miso;
        spi_sck = ~cpol_m;
        wait_clk(HALF);
        spi_sck = cpol_m;
      end else begin
        spi_sck = ~cpol_m;
        spi_mosi = mo[b];
        wait_clk(HALF);
        mi[b] = spi_miso;
        spi_sck = cpol_m;
        wait_clk(HALF);
      end
    end
  endtask

  task automatic frame1(input logic [7:0] mo, output logic [7:0] mi);
    spi_begin();
    spi_bits(mo, 8, mi);
    spi_end();
  endtask

  logic [31:0] v;
  logic [7:0]  mi;
  logic [7:0]  txb [4];
  int rx_r, rx_w, tx_w;

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    rd(R_CTRL, v); chk("R1 ctrl", v, 32'hC);
    rd(R_FCTL, v); chk("R1 fifoctl", v, 32'h0);
    rd(R_IDLE, v); chk("R1 idle", v, 32'hFF);
    rd(R_STAT, v); chk("R1 status", v, 32'h4);
    rd(R_RXWP, v); chk("R1 rxwp", v, 0);
    rd(R_TXRP, v); chk("R1 txrp", v, 0);

    wr(R_FCTL, 32'h12);
    rx_r = 0; rx_w = 0; tx_w = 0;

    // R2 R3 R4 R5 sweep over modes and bit orders
    for (int c = 0; c < 8; c++) begin
      cpol_m = c[2]; cpha_m = c[1]; msb_m = c[0];
      wr(R_CTRL, {28'd0, msb_m, msb_m, cpol_m, cpha_m});
      for (int k = 0; k < 4; k++) txb[k] = 8'(c * 29 + k * 7 + 3);
      wr(R_WORD, {txb[3], txb[2], txb[1], txb[0]});
      tx_w = (tx_w + 4) % 32;
      wr(R_TXWP, 32'(tx_w));
      spi_begin();
      for (int k = 0; k < 5; k++) begin
        spi_bits(8'(c * 53 + k * 11 + 129), 8, mi);
        if (k < 4) chk("R3 miso byte", {24'd0, mi}, {24'd0, txb[k]});
        else       chk("R4 idle after empty", {24'd0, mi}, 32'hFF);
      end
      spi_end();
      rx_w = (rx_w + 5) % 32;
      rd(R_RXWP, v); chk("R5 rxwp", v, 32'(rx_w));
      rd(R_TXRP, v); chk("R3 txrp", v, 32'(tx_w));
      for (int k = 0; k < 5; k++) begin
        rd(R_PEEK, v); chk("R2 rx byte", v, {24'd0, 8'(c * 53 + k * 11 + 129)});
        rx_r = (rx_r + 1) % 32;
        wr(R_RXRP, 32'(rx_r));
      end
    end

    // back to mode 0 MSB first
    cpol_m = 0; cpha_m = 0; msb_m = 1;
    wr(R_CTRL, 32'hC);

    // R4 programmable idle, and TX disabled
    wr(R_IDLE, 32'h5A);
    frame1(8'h00, mi); chk("R4 idle programmed", {24'd0, mi}, 32'h5A);
    wr(R_WORD, 32'h44332211);
    wr(R_TXWP, 32'(tx_w + 4));
    wr(R_FCTL, 32'h10);
    frame1(8'h00, mi); chk("R4 tx disabled idle", {24'd0, mi}, 32'h5A);
    rd(R_TXRP, v); chk("R4 txrp held", v, 32'(tx_w));

    // R9 self-clearing resets
    wr(R_FCTL, 32'h13);
    rd(R_FCTL, v); chk("R9 tx reset bit cleared", v, 32'h12);
    rd(R_TXWP, v); chk("R9 txwp zero", v, 0);
    rd(R_TXRP, v); chk("R9 txrp zero", v, 0);
    wr(R_FCTL, 32'h1A);
    rd(R_FCTL, v); chk("R9 rx reset bit cleared", v, 32'h12);
    rd(R_RXWP, v); chk("R9 rxwp zero", v, 0);
    rd(R_STAT, v); chk("R9 tx empty", {31'd0, v[2]}, 1);

    // R7 level interrupt
    wr(R_THR, 2);
    wr(R_IEN, 1);
    spi_begin(); spi_bits(8'h10, 8, mi); spi_bits(8'h11, 8, mi); spi_end();
    chk("R7 level at threshold", {31'd0, irq_rx_level}, 0);
    frame1(8'h12, mi);
    chk("R7 level above threshold", {31'd0, irq_rx_level}, 1);
    rd(R_STAT, v); chk("R7 status level", {31'd0, v[0]}, 1);
    wr(R_RXRP, 1);
    wait_clk(1);
    chk("R7 level falls", {31'd0, irq_rx_level}, 0);

    // R6 R5 overflow and full boundary
    wr(R_IEN, 0);
    wr(R_FCTL, 32'h1A);
    spi_begin();
    for (int k = 0; k < 17; k++) spi_bits(8'(8'h40 + k), 8, mi);
    spi_end();
    rd(R_RXWP, v); chk("R5 full pointer", v, 32'h10);
    rd(R_STAT, v); chk("R6 overflow set", {31'd0, v[3]}, 1);
    rd(R_PEEK, v); chk("R2 first byte kept", v, 32'h40);
    wr(R_CLR, 32'h8);
    rd(R_STAT, v); chk("R6 overflow cleared", {31'd0, v[3]}, 0);
    wr(R_RXRP, 32'h10);
    spi_begin();
    for (int k = 0; k < 3; k++) spi_bits(8'(8'h60 + k), 8, mi);
    spi_end();
    rd(R_RXWP, v); chk("R5 wrapped rxwp", v, 32'h13);
    rd(R_PEEK, v); chk("R5 wrapped byte", v, 32'h60);
    wr(R_RXRP, 32'h11);
    rd(R_PEEK, v); chk("R5 wrapped next", v, 32'h61);

    // R8 chip-select end event
    wr(R_IEN, 2);
    wr(R_CLR, 2);
    rd(R_STAT, v); chk("R8 flag cleared", {31'd0, v[1]}, 0);
    chk("R8 irq low", {31'd0, irq_cs_deassert}, 0);
    frame1(8'h70, mi);
    rd(R_STAT, v); chk("R8 flag set", {31'd0, v[1]}, 1);
    chk("R8 irq high", {31'd0, irq_cs_deassert}, 1);
    wait_clk(20);
    chk("R8 irq sticky", {31'd0, irq_cs_deassert}, 1);
    wr(R_CLR, 2);
    wr(R_IEN, 0);
    frame1(8'h71, mi);
    rd(R_STAT, v); chk("R8 flag set masked", {31'd0, v[1]}, 1);
    chk("R8 irq masked", {31'd0, irq_cs_deassert}, 0);

    // R11 partial byte
    rd(R_RXWP, v); chk("R11 rxwp before", v, 32'h15);
    spi_begin(); spi_bits(8'hFF, 5, mi); spi_end();
    rd(R_RXWP, v); chk("R11 partial dropped", v, 32'h15);
    frame1(8'hA5, mi);
    rd(R_RXWP, v); chk("R11 next byte stored", v, 32'h16);
    wr(R_RXRP, 32'h15);
    rd(R_PEEK, v); chk("R11 aligned byte", v, 32'hA5);

    // R12 RX disabled
    wr(R_FCTL, 32'h02);
    frame1(8'h3C, mi);
    rd(R_RXWP, v); chk("R12 rxwp held", v, 32'h16);
    rd(R_STAT, v); chk("R12 no overflow", {31'd0, v[3]}, 0);

    // R10 auto-disable
    wr(R_FCTL, 32'h36);
    rd(R_FCTL, v); chk("R10 enables set", v, 32'h36);
    frame1(8'h3D, mi);
    rd(R_FCTL, v); chk("R10 enables cleared", v, 32'h24);
    rd(R_RXWP, v); chk("R10 byte stored in frame", v, 32'h17);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule